// File: doc/BRIEF.md
# Packed SIMD Saturating Arithmetic Unit

This unit treats a 32-bit word as a set of independent lanes, either four bytes or two halfwords, and applies one of eight lane-wise operations to it: add, subtract, halving add, halving subtract, absolute value, left shift, logical right shift and arithmetic right shift. Each operation can treat lanes as signed or unsigned. Add, subtract and left shift can either clamp out-of-range lane results or let them wrap.

Out-of-range lane results are always detected, whether the result is clamped or wrapped. They are recorded in a 32-bit control word as sticky flags, with one flag for the add/subtract/absolute class and one for left shift. A caller presents the operands with a one-cycle `valid_i` strobe. The result and the updated control word appear on the outputs after the next rising edge and stay there until the next strobe.

Top module: `simd_sat_unit`

## Requirements
- R1: `fmt_i`=0 selects four 8-bit lanes and `fmt_i`=1 selects two 16-bit lanes. Lane 0 sits in the least significant bits, and no carry, borrow or shifted bit crosses a lane boundary.
- R2: `op_i` encodes 0=add, 1=subtract, 2=halving add, 3=halving subtract, 4=absolute value, 5=left shift, 6=logical right shift and 7=arithmetic right shift. `sign_i`=1 treats lanes as two's complement for add, subtract, halving and left shift. With `sat_i`=0, out-of-range add/subtract lane results are truncated to the lane width.
- R3: With `sat_i`=1, an add or subtract lane result above the lane maximum becomes that maximum and one below the minimum becomes that minimum. The signed or unsigned limits apply according to `sign_i`.
- R4: Any out-of-range add or subtract lane result sets control bit 20, in both clamping and wrapping mode. An in-range result leaves bit 20 alone.
- R5: Left shift uses only the low 3 bits of `sa_i` for byte lanes and the low 4 bits for halfword lanes. It clamps under `sat_i`=1 and truncates under `sat_i`=0. An out-of-range result sets control bit 22, and no other operation touches bit 22.
- R6: Halving add and subtract produce (a op b) >> 1 computed at full precision. With `round_i`=1, one is added before the shift. These operations never change the control word.
- R7: Arithmetic right shift treats lanes as signed. With `round_i`=1 and a nonzero masked amount s, it adds 1<<(s-1) before shifting. Logical right shift treats lanes as unsigned and never rounds. Both use the masked shift amount of R5.
- R8: Absolute value treats lanes as signed. The most negative lane value yields the lane's signed maximum and sets control bit 20.
- R9: Reset clears the result and the control word. Afterwards control bits are only ever set, never cleared, and every bit other than 20 and 22 stays 0.
- R10: Result and control word update together one clock edge after a cycle with `valid_i`=1. With `valid_i`=0, both hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (R2) |
| fmt_i | input | 1 | Lane format: 0 byte, 1 halfword |
| sign_i | input | 1 | Signed lanes when 1 |
| sat_i | input | 1 | Clamp instead of wrap when 1 |
| round_i | input | 1 | Round halving ops and arithmetic right shift |
| a_i | input | 32 | First operand word |
| b_i | input | 32 | Second operand word |
| sa_i | input | 4 | Shift amount, masked per format |
| result_o | output | 32 | Registered packed result |
| ctl_o | output | 32 | Registered control word with sticky flags |

## Verification
Three effects can land on the same strobe: a lane clamp in the result, a new sticky flag, and a flag that an earlier strobe already set. The bench provokes this in two ways. It issues a left shift that overflows after an add has already set bit 20, and it issues a clean operation after both flags are set. For each strobe it compares the full result word and the full control word against an independent lane model, so a lost or cross-wired flag and a wrong clamp are each caught on their own. It also drives overflowing operand values with the strobe low, to show that neither the result nor the flags move.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
  localparam int unsigned LANE_B = 8;
  localparam int unsigned LANE_H = 16;
  localparam int unsigned SA_W   = $clog2(LANE_H);
  // flag positions decoded by software
  localparam int unsigned OVF_ARITH_BIT = 20;
  localparam int unsigned OVF_SHL_BIT   = 22;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDH = 3'd2,
    OP_SUBH = 3'd3,
    OP_ABS  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHRL = 3'd6,
    OP_SHRA = 3'd7
  } simd_op_e;
endpackage

// File: rtl/simd_lane_core.sv
module simd_lane_core
  import simd_sat_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  simd_op_e                 op_i,
  input  logic                     sign_i,
  input  logic                     sat_i,
  input  logic                     round_i,
  input  logic [W-1:0]             a_i,
  input  logic [W-1:0]             b_i,
  input  logic [$clog2(W)-1:0]     sa_i,
  output logic [W-1:0]             res_o,
  output logic                     ovf_arith_o,
  output logic                     ovf_shl_o
);
  localparam int unsigned X = 2 * W + 2;

  logic signed [X-1:0] ae, be, as_a, ua, rnd, wide, lim_hi, lim_lo;
  logic use_sgn, chk, clamp, over;

  always_comb begin
    ae   = {{(X-W){sign_i & a_i[W-1]}}, a_i};
    be   = {{(X-W){sign_i & b_i[W-1]}}, b_i};
    as_a = {{(X-W){a_i[W-1]}}, a_i};
    ua   = {{(X-W){1'b0}}, a_i};
    rnd  = '0;
    chk  = 1'b0;
    clamp = 1'b0;
    use_sgn = sign_i;
    wide = '0;
    unique case (op_i)
      OP_ADD: begin wide = ae + be; chk = 1'b1; clamp = sat_i; end
      OP_SUB: begin wide = ae - be; chk = 1'b1; clamp = sat_i; end
      OP_ADDH: begin rnd[0] = round_i; wide = (ae + be + rnd) >>> 1; end
      OP_SUBH: begin rnd[0] = round_i; wide = (ae - be + rnd) >>> 1; end
      OP_ABS: begin
        wide = as_a[X-1] ? -as_a : as_a;
        use_sgn = 1'b1; chk = 1'b1; clamp = 1'b1;
      end
      OP_SHL: begin wide = ae <<< sa_i; chk = 1'b1; clamp = sat_i; end
      OP_SHRL: wide = ua >> sa_i;
      OP_SHRA: begin
        if (round_i && sa_i != '0) rnd[sa_i - 1'b1] = 1'b1;
        wide = (as_a + rnd) >>> sa_i;
      end
      default: wide = '0;
    endcase
    lim_hi = use_sgn ? X'((1 << (W-1)) - 1) : X'((1 << W) - 1);
    lim_lo = use_sgn ? -X'(1 << (W-1)) : '0;
    over   = chk && (wide > lim_hi || wide < lim_lo);
    if (clamp && over) res_o = (wide > lim_hi) ? lim_hi[W-1:0] : lim_lo[W-1:0];
    else               res_o = wide[W-1:0];
    ovf_shl_o   = over && (op_i == OP_SHL);
    ovf_arith_o = over && (op_i != OP_SHL);
  end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  simd_op_e                    op_i,
  input  logic                        sign_i,
  input  logic                        sat_i,
  input  logic                        round_i,
  input  logic [DATA_W-1:0]           a_i,
  input  logic [DATA_W-1:0]           b_i,
  input  logic [$clog2(LANE_W)-1:0]   sa_i,
  output logic [DATA_W-1:0]           res_o,
  output logic                        ovf_arith_o,
  output logic                        ovf_shl_o
);
  localparam int unsigned N = DATA_W / LANE_W;

  logic [N-1:0] arith_v, shl_v;

  for (genvar l = 0; l < N; l++) begin : g_lane
    simd_lane_core #(.W(LANE_W)) u_core (
      .op_i        (op_i),
      .sign_i      (sign_i),
      .sat_i       (sat_i),
      .round_i     (round_i),
      .a_i         (a_i[l*LANE_W +: LANE_W]),
      .b_i         (b_i[l*LANE_W +: LANE_W]),
      .sa_i        (sa_i),
      .res_o       (res_o[l*LANE_W +: LANE_W]),
      .ovf_arith_o (arith_v[l]),
      .ovf_shl_o   (shl_v[l])
    );
  end

  assign ovf_arith_o = |arith_v;
  assign ovf_shl_o   = |shl_v;
endmodule

// File: rtl/simd_sat_unit.sv
module simd_sat_unit
  import simd_sat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic              fmt_i,
  input  logic              sign_i,
  input  logic              sat_i,
  input  logic              round_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SA_W-1:0]   sa_i,
  output logic [DATA_W-1:0] result_o,
  output logic [31:0]       ctl_o
);
  localparam int unsigned SA_B = $clog2(LANE_B);
  localparam logic [31:0] FLAG_M = (32'd1 << OVF_ARITH_BIT) | (32'd1 << OVF_SHL_BIT);

  function automatic logic [DATA_W-1:0] sign_mask(int w);
    logic [DATA_W-1:0] m = '0;
    for (int i = w - 1; i < DATA_W; i += w) m[i] = 1'b1;
    return m;
  endfunction

  simd_op_e op;
  logic [DATA_W-1:0] res_b, res_h, res_d;
  logic ar_b, ar_h, sh_b, sh_h;
  logic [31:0] flags_d;
  logic [DATA_W-1:0] res_q;
  logic [31:0] ctl_q;

  assign op = simd_op_e'(op_i);

  simd_lane_array #(.DATA_W(DATA_W), .LANE_W(LANE_B)) u_bytes (
    .op_i(op), .sign_i(sign_i), .sat_i(sat_i), .round_i(round_i),
    .a_i(a_i), .b_i(b_i), .sa_i(sa_i[SA_B-1:0]),
    .res_o(res_b), .ovf_arith_o(ar_b), .ovf_shl_o(sh_b)
  );

  simd_lane_array #(.DATA_W(DATA_W), .LANE_W(LANE_H)) u_halves (
    .op_i(op), .sign_i(sign_i), .sat_i(sat_i), .round_i(round_i),
    .a_i(a_i), .b_i(b_i), .sa_i(sa_i),
    .res_o(res_h), .ovf_arith_o(ar_h), .ovf_shl_o(sh_h)
  );

  always_comb begin
    res_d   = fmt_i ? res_h : res_b;
    flags_d = '0;
    flags_d[OVF_ARITH_BIT] = fmt_i ? ar_h : ar_b;
    flags_d[OVF_SHL_BIT]   = fmt_i ? sh_h : sh_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ctl_q <= '0;
    end else if (valid_i) begin
      res_q <= res_d;
      ctl_q <= ctl_q | flags_d;
    end
  end

  assign result_o = res_q;
  assign ctl_o    = ctl_q;

  AST_CTL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ctl_o & $past(ctl_o)) == $past(ctl_o)));  // R9
  AST_CTL_ONLY_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o & ~FLAG_M) == '0);  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(ctl_o)));  // R10
  AST_SHL_FLAG_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != OP_SHL) |=> (ctl_o[OVF_SHL_BIT] == $past(ctl_o[OVF_SHL_BIT])));  // R5
  AST_HALVE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_ADDH || op_i == OP_SUBH)) |=> $stable(ctl_o));  // R6
  AST_ABS_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ABS) |=>
      ((result_o & ($past(fmt_i) ? sign_mask(LANE_H) : sign_mask(LANE_B))) == '0));  // R8
endmodule

// File: tb/simd_sat_unit_tb.sv
`timescale 1ns/1ps
module simd_sat_unit_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic fmt_i = 1'b0, sign_i = 1'b0, sat_i = 1'b0, round_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [3:0] sa_i = '0;
  logic [31:0] result_o, ctl_o;

  simd_sat_unit dut_i (.*);

  always #10 clk_i = ~clk_i;

  typedef struct { logic [31:0] res; logic [31:0] ctl; string tag; } exp_t;
  exp_t q[$];
  int tests = 0, fails = 0;
  logic [31:0] exp_ctl = '0, last_res = '0;
  logic pend = 1'b0;
  bit done = 1'b0;

  always @(posedge clk_i) pend <= valid_i;

  function automatic void model(input int op, input bit fmt, sgn, sat, rnd,
                                input logic [31:0] a, b, input int sa,
                                output logic [31:0] r, output bit fa, fs);
    int w = fmt ? 16 : 8;
    int n = 32 / w;
    longint m = (64'sd1 << w) - 1;
    int s = sa & (w - 1);
    r = '0; fa = 0; fs = 0;
    for (int l = 0; l < n; l++) begin
      longint ua, ub, xa, xb, va, vb, hi, lo, v;
      bit chk, clamp;
      ua = (longint'(a) >> (l * w)) & m;
      ub = (longint'(b) >> (l * w)) & m;
      xa = ((ua >> (w - 1)) & 1) != 0 ? ua - (m + 1) : ua;
      xb = ((ub >> (w - 1)) & 1) != 0 ? ub - (m + 1) : ub;
      va = sgn ? xa : ua;
      vb = sgn ? xb : ub;
      hi = sgn ? (m >> 1) : m;
      lo = sgn ? -(m >> 1) - 1 : 0;
      chk = 0; clamp = 0; v = 0;
      case (op)
        0: begin v = va + vb; chk = 1; clamp = sat; end
        1: begin v = va - vb; chk = 1; clamp = sat; end
        2: v = (va + vb + longint'(rnd)) >>> 1;
        3: v = (va - vb + longint'(rnd)) >>> 1;
        4: begin v = xa < 0 ? -xa : xa; hi = m >> 1; lo = -(m >> 1) - 1; chk = 1; clamp = 1; end
        5: begin v = va <<< s; chk = 1; clamp = sat; end
        6: v = ua >> s;
        default: v = (xa + ((rnd && s != 0) ? (64'sd1 << (s - 1)) : 64'sd0)) >>> s;
      endcase
      if (chk && (v > hi || v < lo)) begin
        if (op == 5) fs = 1; else fa = 1;
        if (clamp) v = (v > hi) ? hi : lo;
      end
      r |= 32'((v & m) << (l * w));
    end
  endfunction

  task automatic run(input string tag, input int op, input bit fmt, sgn, sat, rnd,
                     input logic [31:0] a, b, input int sa);
    exp_t e;
    logic [31:0] r;
    bit fa, fs;
    model(op, fmt, sgn, sat, rnd, a, b, sa, r, fa, fs);
    if (fa) exp_ctl[20] = 1'b1;
    if (fs) exp_ctl[22] = 1'b1;
    e.res = r; e.ctl = exp_ctl; e.tag = tag;
    q.push_back(e);
    last_res = r;
    @(negedge clk_i);
    op_i = 3'(op); fmt_i = fmt; sign_i = sgn; sat_i = sat; round_i = rnd;
    a_i = a; b_i = b; sa_i = 4'(sa); valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor: pops one expected item per accepted strobe
  always @(negedge clk_i) begin
    if (pend && rst_ni) begin
      exp_t e;
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL %s: result with no expected item, act=%h exp=none", "R10", result_o);
      end else begin
        e = q.pop_front();
        if (result_o !== e.res || ctl_o !== e.ctl) begin
          fails++;
          $display("FAIL %s: act res=%h ctl=%h exp res=%h ctl=%h",
                   e.tag, result_o, ctl_o, e.res, e.ctl);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    exp_ctl = '0;
    last_res = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 reset result", result_o, 32'h0);
    check("R9 reset ctl", ctl_o, 32'h0);

    run("R1 byte unsigned wrap add", 0, 0, 0, 0, 0, 32'h01020304, 32'h10203040, 0);
    run("R1 half lanes no carry", 0, 1, 1, 0, 0, 32'h10000001, 32'h0001FFFF, 0);
    run("R2 byte unsigned wrap sub", 1, 0, 0, 0, 0, 32'h00050010, 32'h01010020, 0);
    run("R3 byte signed clamp add", 0, 0, 1, 1, 0, 32'h7F80407F, 32'h01FF4001, 0);
    run("R3 half unsigned clamp sub", 1, 1, 0, 1, 0, 32'h00051000, 32'h00100001, 0);

    do_reset();
    run("R4 in-range add no flag", 0, 1, 1, 0, 0, 32'h10002000, 32'h01000100, 0);
    run("R4 wrap overflow flags", 0, 1, 1, 0, 0, 32'h7FFF0000, 32'h00010000, 0);

    do_reset();
    run("R5 byte shl clamp masked", 5, 0, 1, 1, 0, 32'h40010280, 32'h0, 9);
    run("R5 half shl unsigned wrap", 5, 1, 0, 0, 0, 32'h20000101, 32'h0, 3);

    do_reset();
    run("R6 byte addh round", 2, 0, 1, 0, 1, 32'h7F7F0180, 32'h7F01FF80, 0);
    run("R6 half subh unsigned", 3, 1, 0, 1, 0, 32'h00030100, 32'h00050001, 0);
    check("R6 ctl untouched", ctl_o, 32'h0);
    run("R7 half shra round", 7, 1, 0, 0, 1, 32'h80017FFF, 32'h0, 4);
    run("R7 byte shrl masked", 6, 0, 1, 0, 1, 32'h80FF4001, 32'h0, 15);
    run("R7 byte shra sa zero", 7, 0, 1, 0, 1, 32'h80FF4001, 32'h0, 0);
    run("R7 byte shra round", 7, 0, 0, 0, 1, 32'h80FF7F03, 32'h0, 1);

    do_reset();
    run("R8 byte abs min", 4, 0, 0, 0, 0, 32'h80FF7F00, 32'h0, 0);
    do_reset();
    run("R8 half abs", 4, 1, 0, 0, 0, 32'h7FFF8001, 32'h0, 0);
    check("R8 no flag when in range", ctl_o, 32'h0);

    do_reset();
    run("R9 add sets arith flag", 0, 0, 0, 1, 0, 32'hFF000000, 32'h01000000, 0);
    run("R9 shl adds shl flag", 5, 0, 1, 1, 0, 32'h00000040, 32'h0, 2);
    run("R9 clean op keeps flags", 0, 0, 0, 0, 0, 32'h01010101, 32'h01010101, 0);

    @(negedge clk_i);
    op_i = 3'd5; fmt_i = 1'b0; sat_i = 1'b0; a_i = 32'hFFFFFFFF; sa_i = 4'd7;
    repeat (3) @(negedge clk_i);
    check("R10 hold result", result_o, last_res);
    check("R10 hold ctl", ctl_o, exp_ctl);
    do_reset();
    @(negedge clk_i);
    op_i = 3'd0; a_i = 32'hFFFFFFFF; b_i = 32'hFFFFFFFF;
    repeat (3) @(negedge clk_i);
    check("R10 idle no flag", ctl_o, 32'h0);

    repeat (2) @(negedge clk_i);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10: act=%0d pending exp=0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule